// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This controller sits on the host side of an asynchronous parallel flash. A client asks for a word program or a sector erase with a one-cycle `start` pulse. The request carries the operation type, the target address, the data word and the detection method. The controller then performs these steps:

- It writes the unlock and command words onto the flash bus with a small state machine.
- It polls the part with reads until the part reports that the internal operation has ended.
- It raises `done` for one cycle, with `error` valid in the same cycle.

Bus timing is expressed in clock cycles. Every access holds its strobe low for `STROBE` cycles. Accesses are always separated by at least one cycle with every strobe high.

Completion is detected in one of two ways:

- **Status-bit-7 method:** a program is finished once bit 7 reads back equal to bit 7 of the data being written. An erase is finished once bit 7 reads 1.
- **Toggle method:** the operation is finished when bit 6 holds the same value in two consecutive reads.

After a program, the other data bits may still be settling. The controller therefore waits `SETTLE_CYC` cycles, reads the whole word once more and compares it with the intended data. If completion never appears within `POLL_LIMIT` polling reads, the controller gives up and flags an error.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `error` are low, and `bus_wr_n`, `bus_rd_n` and `bus_sel_n` are high.
- R2: A program request issues exactly four writes, in this order: (0x5555, 0x00AA), (0x2AAA, 0x0055), (0x5555, 0x00A0), then (target, data).
- R3: An erase request issues exactly six writes, in this order: (0x5555, 0x00AA), (0x2AAA, 0x0055), (0x5555, 0x0080), (0x5555, 0x00AA), (0x2AAA, 0x0055), then (target, 0x0030).
- R4: Every write or read strobe stays low for exactly `STROBE` cycles. Both strobes are high for at least one cycle before any strobe falls. The write and read strobes are never low together, so polling reads start only after the last write strobe has been released.
- R5: In status-bit-7 mode, polling stops at the first read whose bit 7 equals the data's bit 7 (program) or equals 1 (erase).
- R6: In toggle mode, polling stops at the first read whose bit 6 equals bit 6 of the read just before it. The first polling read alone never ends polling.
- R7: After a program completes, at least `SETTLE_CYC` cycles pass with the read strobe high, and then one final read of the target occurs. `error` is set if that word differs from the data in any bit. An erase ends without a final read.
- R8: If `POLL_LIMIT` polling reads pass without completion, the controller issues no further reads and ends with `error` high.
- R9: `busy` is high from the cycle after `start` until `done`. `done` is a single-cycle pulse during which `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request pulse, taken while idle |
| op_erase | input | 1 | 1 = sector erase, 0 = word program |
| poll_toggle | input | 1 | 1 = bit-6 toggle method, 0 = bit-7 status method |
| target | input | AW | Word or sector address of the operation |
| wdata | input | DW | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Timeout or final-word mismatch, valid with `done` |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | DW | Flash write data |
| bus_drive | output | 1 | Enables the host data drivers during writes |
| bus_rdata | input | DW | Flash read data |
| bus_sel_n | output | 1 | Flash select, low during any access |
| bus_wr_n | output | 1 | Flash write strobe, active low |
| bus_rd_n | output | 1 | Flash read strobe, active low |

## Verification
The assertions place no restriction on `bus_rdata`, because polling must terminate on any returned pattern. They do assume that `start` matters only while `busy` is low. The bench therefore pulses `start` only after the previous `done`. It drives read data from a flash model that reacts solely to strobe edges, so the returned word stays stable for the whole low phase of every read strobe.

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int STROBE = 3,
  parameter int SETTLE_CYC = 200,
  parameter int POLL_LIMIT = 100000,
  parameter logic [AW-1:0] UNLOCK_A = AW'(16'h5555),
  parameter logic [AW-1:0] UNLOCK_B = AW'(16'h2AAA)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic          poll_toggle,
  input  logic [AW-1:0] target,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_drive,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_sel_n,
  output logic          bus_wr_n,
  output logic          bus_rd_n
);

  localparam int CMAX = (STROBE > SETTLE_CYC) ? STROBE : SETTLE_CYC;
  localparam int CW = $clog2(CMAX + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_WREC, S_RD, S_RREC, S_SETTLE} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] npoll;
  logic [2:0]    step;
  logic          is_erase, use_tog, final_rd;
  logic          have_samp, have_prev, prev6;
  logic [AW-1:0] tgt;
  logic [DW-1:0] wd, samp;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  always_comb begin
    cmd_addr = UNLOCK_A;
    cmd_data = DW'(8'hAA);
    unique case (step)
      3'd0: ;
      3'd1: begin cmd_addr = UNLOCK_B; cmd_data = DW'(8'h55); end
      3'd2: cmd_data = is_erase ? DW'(8'h80) : DW'(8'hA0);
      3'd3: if (!is_erase) begin cmd_addr = tgt; cmd_data = wd; end
      3'd4: begin cmd_addr = UNLOCK_B; cmd_data = DW'(8'h55); end
      default: begin cmd_addr = tgt; cmd_data = DW'(8'h30); end
    endcase
  end

  wire last_step  = (step == (is_erase ? 3'd5 : 3'd3));
  wire strobe_end = (cnt == CW'(STROBE - 1));
  wire settle_end = (cnt == CW'(SETTLE_CYC - 1));
  wire hit = use_tog ? (have_prev && (samp[6] == prev6))
                     : (samp[7] == (is_erase | wd[7]));

  assign busy      = (st != S_IDLE);
  assign bus_drive = (st == S_WR);
  assign bus_wr_n  = (st != S_WR);
  assign bus_rd_n  = (st != S_RD);
  assign bus_sel_n = bus_wr_n & bus_rd_n;
  assign bus_addr  = (st == S_WR) ? cmd_addr : tgt;
  assign bus_wdata = cmd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; npoll <= '0; step <= '0;
      is_erase <= 1'b0; use_tog <= 1'b0; final_rd <= 1'b0;
      have_samp <= 1'b0; have_prev <= 1'b0; prev6 <= 1'b0;
      tgt <= '0; wd <= '0; samp <= '0; done <= 1'b0; error <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          is_erase <= op_erase; use_tog <= poll_toggle;
          tgt <= target; wd <= wdata;
          step <= '0; cnt <= '0; error <= 1'b0; st <= S_WR;
        end
        S_WR: begin
          cnt <= strobe_end ? '0 : cnt + 1'b1;
          if (strobe_end) st <= S_WREC;
        end
        S_WREC: begin
          cnt <= '0;
          if (last_step) begin
            st <= S_RD; npoll <= '0; final_rd <= 1'b0;
            have_samp <= 1'b0; have_prev <= 1'b0;
          end else begin
            step <= step + 1'b1; st <= S_WR;
          end
        end
        S_RD: begin
          cnt <= strobe_end ? '0 : cnt + 1'b1;
          if (strobe_end) begin
            samp <= bus_rdata; prev6 <= samp[6];
            have_prev <= have_samp; have_samp <= 1'b1;
            st <= S_RREC;
          end
        end
        S_RREC: begin
          if (final_rd) begin
            error <= (samp != wd); done <= 1'b1; st <= S_IDLE;
          end else if (hit) begin
            if (is_erase) begin done <= 1'b1; st <= S_IDLE; end
            else begin cnt <= '0; st <= S_SETTLE; end
          end else if (npoll == PW'(POLL_LIMIT - 1)) begin
            error <= 1'b1; done <= 1'b1; st <= S_IDLE;
          end else begin
            npoll <= npoll + 1'b1; st <= S_RD;
          end
        end
        S_SETTLE: begin
          cnt <= settle_end ? '0 : cnt + 1'b1;
          if (settle_end) begin final_rd <= 1'b1; st <= S_RD; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] wr_run, rd_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin wr_run <= '0; rd_run <= '0; end
    else begin
      wr_run <= bus_wr_n ? '0 : wr_run + 1'b1;
      rd_run <= bus_rd_n ? '0 : rd_run + 1'b1;
    end
  end

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_n || bus_rd_n);
  // R4
  wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> wr_run == CW'(STROBE));
  // R4
  rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> rd_run == CW'(STROBE));
  // R4
  rd_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd_n) |-> $past(bus_wr_n && bus_rd_n));
  // R4
  wr_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> $past(bus_wr_n && bus_rd_n));
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

endmodule

// File: tb/flash_poll_ctrl_test.sv
`timescale 1ns/1ps
module flash_poll_ctrl_test;
  localparam int AW = 16, DW = 16, STROBE = 2, SETTLE = 5, LIMIT = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op_erase = 1'b0, poll_toggle = 1'b0;
  logic [AW-1:0] target = '0;
  logic [DW-1:0] wdata = '0;
  logic busy, done, error, bus_drive, bus_sel_n, bus_wr_n, bus_rd_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  flash_poll_ctrl #(.AW(AW), .DW(DW), .STROBE(STROBE), .SETTLE_CYC(SETTLE),
                    .POLL_LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .poll_toggle(poll_toggle), .target(target), .wdata(wdata),
    .busy(busy), .done(done), .error(error), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_drive(bus_drive), .bus_rdata(bus_rdata),
    .bus_sel_n(bus_sel_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n));

  int checks = 0, errors = 0;

  // flash model
  logic          m_erase = 1'b0, m_corrupt = 1'b0, tog = 1'b0;
  int            busy_cfg = 0, busy_left = 0, wcount = 0, nreads = 0;
  logic [15:0]   mem_word = 16'hFFFF, lat_a = '0, lat_d = '0;
  logic [15:0]   wa_log [8];
  logic [15:0]   wd_log [8];
  realtime       last_end = 0, last_gap = 0;

  assign bus_rdata = (busy_left > 0)
    ? (m_erase ? {8'h00, 1'b0, tog, 6'h2A} : {8'h00, ~mem_word[7], tog, 6'h15})
    : mem_word;

  always @(negedge clk) if (!bus_wr_n) begin lat_a = bus_addr; lat_d = bus_wdata; end

  always @(posedge bus_wr_n) if (rst_n) begin
    if (wcount < 8) begin wa_log[wcount] = lat_a; wd_log[wcount] = lat_d; end
    wcount++;
    if (!m_erase && wcount == 4) begin
      mem_word = lat_d ^ (m_corrupt ? 16'h0100 : 16'h0000);
      busy_left = busy_cfg; tog = 1'b0;
    end
    if (m_erase && wcount == 6) begin
      mem_word = 16'hFFFF; busy_left = busy_cfg; tog = 1'b0;
    end
  end

  always @(negedge bus_rd_n) if (rst_n) last_gap = ($realtime - last_end) / 5.0;
  always @(posedge bus_rd_n) if (rst_n) begin
    nreads++; last_end = $realtime;
    if (busy_left > 0) begin busy_left--; tog = ~tog; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // read index (1-based) at which bit 6 first repeats
  function automatic int tog_hit(int b, bit d6);
    for (int k = 2; k < 100; k++) begin
      bit cur  = (k <= b) ? bit'((k - 1) % 2) : d6;
      bit prev = (k - 1 <= b) ? bit'((k - 2) % 2) : d6;
      if (cur == prev) return k;
    end
    return 100;
  endfunction

  task automatic run_op(input bit er, input bit tg, input int b,
                        input logic [15:0] d, input bit bad, input logic [15:0] ta);
    int poll, exp_reads, cyc;
    bit exp_err, tmo;
    string rq;
    logic [15:0] ea [6];
    logic [15:0] ed [6];
    m_erase = er; m_corrupt = bad; busy_cfg = b;
    wcount = 0; nreads = 0; busy_left = 0; last_gap = 0;
    poll = tg ? tog_hit(b, er ? 1'b1 : d[6]) : b + 1;
    tmo = (poll > LIMIT);
    if (tmo) poll = LIMIT;
    exp_reads = poll + ((!er && !tmo) ? 1 : 0);
    exp_err = tmo || (!er && bad);
    @(negedge clk);
    op_erase = er; poll_toggle = tg; wdata = d; target = ta; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R9", "busy after start", busy, 1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 3000) begin @(negedge clk); cyc++; end
    check(done === 1'b1, "R9", "done seen", done, 1);
    check(busy === 1'b0, "R9", "busy low at done", busy, 0);
    rq = tmo ? "R8" : (!er && bad) ? "R7" : tg ? "R6" : "R5";
    check(error === exp_err, rq, "error flag", error, exp_err);
    check(nreads == exp_reads, rq, "read count", nreads, exp_reads);
    if (!er && !tmo)
      check(last_gap >= SETTLE, "R7", "settle gap cycles", longint'(last_gap), SETTLE);
    ea = '{16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA, ta};
    ed = '{16'h00AA, 16'h0055, 16'h0080, 16'h00AA, 16'h0055, 16'h0030};
    if (!er) begin ea[2] = 16'h5555; ed[2] = 16'h00A0; ea[3] = ta; ed[3] = d; end
    check(wcount == (er ? 6 : 4), er ? "R3" : "R2", "write count", wcount, er ? 6 : 4);
    for (int i = 0; i < (er ? 6 : 4); i++) begin
      check(wa_log[i] == ea[i], er ? "R3" : "R2", "write addr", wa_log[i], ea[i]);
      check(wd_log[i] == ed[i], er ? "R3" : "R2", "write data", wd_log[i], ed[i]);
    end
    @(negedge clk);
    check(done === 1'b0, "R9", "done single pulse", done, 0);
  endtask

  initial begin
    #900_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && done === 1'b0 && error === 1'b0, "R1", "flags in reset",
          {busy, done, error}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_wr_n === 1'b1 && bus_rd_n === 1'b1 && bus_sel_n === 1'b1, "R1",
          "strobes idle", {bus_wr_n, bus_rd_n, bus_sel_n}, 7);
    check(busy === 1'b0, "R1", "idle after reset", busy, 0);
    // R4 is guarded by assertions throughout the sweep
    for (int tg = 0; tg < 2; tg++)
      for (int b = 0; b < 6; b++) begin
        for (int p = 0; p < 4; p++)
          run_op(1'b0, bit'(tg), b, {8'h5A + 8'(p * 17), p[1], p[0], 6'h0B}, 1'b0,
                 16'h0100 + 16'(b));
        run_op(1'b1, bit'(tg), b, 16'h0000, 1'b0, 16'h8000 + 16'(b));
      end
    for (int tg = 0; tg < 2; tg++) begin
      run_op(1'b0, bit'(tg), 2, 16'h00C3, 1'b1, 16'h0042);   // R7 mismatch
      run_op(1'b0, bit'(tg), 20, 16'h0081, 1'b0, 16'h0043);  // R8 timeout
      run_op(1'b1, bit'(tg), 20, 16'h0000, 1'b0, 16'h4000);  // R8 timeout
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule